// File: doc/BRIEF.md
# Banked Interrupt Controller with Shortcut Status

This block gathers 72 level-sensitive interrupt sources into one processor interrupt line. The sources fall into three groups: eight local sources (global numbers 0 to 7), a first bank of 32 peripheral sources (numbers 8 to 39) and a second bank of 32 (numbers 40 to 71). Each source has one enable bit. Software never writes an enable word directly. It writes ones into a "set" register to turn sources on and ones into a separate "clear" register to turn them off, so several agents can change enables without a read-modify-write sequence.

Software reads the pending status through three words. Each bank has a pending word. A folded top-level word carries the local sources, one summary flag per bank, and direct copies of eleven often-used bank sources. An interrupt handler can often find its source with a single read of that top-level word. The summary flags leave out the sources that already have a direct copy. A set summary flag therefore means a second read of the bank word is needed. A stored fast-interrupt control byte is kept for software, but it has no routing effect.

Top module: `irqc_banked`

## Requirements
- R1: After synchronous reset every enable is 0, the fast-interrupt control byte is 0, every pending word reads 0 and `cpu_irq` is low.
- R2: A write to a set register (0x18 local, 0x10 bank 1, 0x14 bank 2) turns on the enable of each source whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to a clear register (0x24 local, 0x1C bank 1, 0x20 bank 2) turns off the enable of each source whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R4: The bank 1 pending word (0x04) equals `src_level[39:8]` ANDed with the bank 1 enables, and the bank 2 pending word (0x08) equals `src_level[71:40]` ANDed with the bank 2 enables. Writes to any pending word have no effect.
- R5: In the top-level pending word (0x00), bits 7:0 are the enabled local sources `src_level[7:0]`, and bits 31:21 are always 0.
- R6: Top-level bit 8 is the OR of the enabled bank 1 pending bits other than bank positions 7, 9, 10, 18 and 19. Top-level bit 9 is the OR of the enabled bank 2 pending bits other than positions 21, 22, 23, 24, 25 and 30.
- R7: Top-level bits 10 to 14 copy bank 1 pending positions 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy bank 2 pending positions 21, 22, 23, 24, 25 and 30, in that order.
- R8: `cpu_irq` is high exactly when at least one source is both high and enabled, and it follows `src_level` in the same cycle.
- R9: The set registers read back the current enable mask of their group, with the upper 24 bits 0 for the local group. The clear registers read as 0.
- R10: Offset 0x0C stores bits 7:0 of a write and reads them back, with bits 31:8 as 0.
- R11: Any other byte address, including misaligned ones, reads as 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 72 | Raw source levels, bit n is global source n |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
The hardest case to reach is a bank where every pending source has a shortcut bit. In that case the summary flag must stay low while the shortcut bits and `cpu_irq` are high. Random enables and levels almost never produce it. Directed steps enable a single shortcut source, then add one non-shortcut neighbour and check that the summary flag rises. Random set/clear traffic on all three groups then runs against a bench model of the enables and of the folded word.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LOCAL_N = 8;
    localparam int BANK_N  = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int FCTL_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_TOP_PEND = 8'h00,
        RA_B1_PEND  = 8'h04,
        RA_B2_PEND  = 8'h08,
        RA_FCTL     = 8'h0C,
        RA_B1_SET   = 8'h10,
        RA_B2_SET   = 8'h14,
        RA_LOC_SET  = 8'h18,
        RA_B1_CLR   = 8'h1C,
        RA_B2_CLR   = 8'h20,
        RA_LOC_CLR  = 8'h24
    } reg_addr_e;

    // Folded top-level word layout
    localparam int SUM1_BIT = LOCAL_N;
    localparam int SUM2_BIT = LOCAL_N + 1;
    localparam int SC1_N    = 5;
    localparam int SC2_N    = 6;
    localparam int SC1_BASE = LOCAL_N + 2;
    localparam int SC2_BASE = SC1_BASE + SC1_N;
    localparam int TOP_USED = SC2_BASE + SC2_N;

    localparam int SC1_IDX [SC1_N] = '{7, 9, 10, 18, 19};
    localparam int SC2_IDX [SC2_N] = '{21, 22, 23, 24, 25, 30};

    function automatic logic [BANK_N-1:0] sc1_mask();
        logic [BANK_N-1:0] m = '0;
        for (int i = 0; i < SC1_N; i++) m[SC1_IDX[i]] = 1'b1;
        return m;
    endfunction

    function automatic logic [BANK_N-1:0] sc2_mask();
        logic [BANK_N-1:0] m = '0;
        for (int i = 0; i < SC2_N; i++) m[SC2_IDX[i]] = 1'b1;
        return m;
    endfunction

    // group 0 = local, 1 = bank 1, 2 = bank 2
    function automatic logic [ADDR_W-1:0] set_ofs(int g);
        case (g)
            0:       return RA_LOC_SET;
            1:       return RA_B1_SET;
            default: return RA_B2_SET;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] clr_ofs(int g);
        case (g)
            0:       return RA_LOC_CLR;
            1:       return RA_B1_CLR;
            default: return RA_B2_CLR;
        endcase
    endfunction

endpackage

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wbits,
    input  logic [W-1:0] raw,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (set_we) en_q <= en_q | wbits;
        else if (clr_we) en_q <= en_q & ~wbits;
    end

    assign pend = raw & en_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_q & $past(wbits)) == $past(wbits)));                                   // R2
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));                // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((en_q & $past(wbits)) == '0));                                // R3
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(en_q));                                               // R3

endmodule

// File: rtl/irqc_fold.sv
module irqc_fold
    import irqc_pkg::*;
(
    input  logic [LOCAL_N-1:0] loc_pend,
    input  logic [BANK_N-1:0]  b1_pend,
    input  logic [BANK_N-1:0]  b2_pend,
    output logic [DATA_W-1:0]  top_word
);

    localparam logic [BANK_N-1:0] M1 = sc1_mask();
    localparam logic [BANK_N-1:0] M2 = sc2_mask();

    assign top_word[LOCAL_N-1:0] = loc_pend;
    assign top_word[SUM1_BIT]    = |(b1_pend & ~M1);
    assign top_word[SUM2_BIT]    = |(b2_pend & ~M2);

    for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
        assign top_word[SC1_BASE + k] = b1_pend[SC1_IDX[k]];
    end

    for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
        assign top_word[SC2_BASE + k] = b2_pend[SC2_IDX[k]];
    end

    assign top_word[DATA_W-1:TOP_USED] = '0;

endmodule

// File: rtl/irqc_banked.sv
module irqc_banked
    import irqc_pkg::*;
#(
    parameter int N_LOC  = LOCAL_N,
    parameter int N_BANK = BANK_N,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int FW     = FCTL_W,
    localparam int SRC_N = N_LOC + 2 * N_BANK,
    localparam int GRP_N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_level,
    input  logic             reg_wen,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             cpu_irq
);

    logic [GRP_N-1:0][N_BANK-1:0] en_pad;
    logic [GRP_N-1:0][N_BANK-1:0] pend_pad;
    logic [GRP_N-1:0]             set_we, clr_we;
    logic [FW-1:0]                fctl_q;
    logic [DW-1:0]                top_word;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        localparam int W  = (g == 0) ? N_LOC : N_BANK;
        localparam int LO = (g == 0) ? 0 : N_LOC + (g - 1) * N_BANK;

        assign set_we[g] = reg_wen && (reg_addr == set_ofs(g));
        assign clr_we[g] = reg_wen && (reg_addr == clr_ofs(g));

        irqc_en_bank #(.W(W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_we (set_we[g]),
            .clr_we (clr_we[g]),
            .wbits  (reg_wdata[W-1:0]),
            .raw    (src_level[LO +: W]),
            .en_q   (en_pad[g][W-1:0]),
            .pend   (pend_pad[g][W-1:0])
        );

        if (W < N_BANK) begin : g_pad
            assign en_pad[g][N_BANK-1:W]   = '0;
            assign pend_pad[g][N_BANK-1:W] = '0;
        end
    end

    irqc_fold u_fold (
        .loc_pend (pend_pad[0][N_LOC-1:0]),
        .b1_pend  (pend_pad[1]),
        .b2_pend  (pend_pad[2]),
        .top_word (top_word)
    );

    always_ff @(posedge clk) begin
        if (rst)                                       fctl_q <= '0;
        else if (reg_wen && reg_addr == AW'(RA_FCTL)) fctl_q <= reg_wdata[FW-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(RA_TOP_PEND): reg_rdata = top_word;
            AW'(RA_B1_PEND):  reg_rdata = DW'(pend_pad[1]);
            AW'(RA_B2_PEND):  reg_rdata = DW'(pend_pad[2]);
            AW'(RA_FCTL):     reg_rdata = DW'(fctl_q);
            AW'(RA_LOC_SET):  reg_rdata = DW'(en_pad[0]);
            AW'(RA_B1_SET):   reg_rdata = DW'(en_pad[1]);
            AW'(RA_B2_SET):   reg_rdata = DW'(en_pad[2]);
            default:          reg_rdata = '0;
        endcase
    end

    assign cpu_irq = |pend_pad;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (|src_level));                                                             // R8
    AST_IRQ_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
        (top_word == '0) |-> !cpu_irq);                                                        // R8
    AST_SUM1_SHORTCUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((pend_pad[1] & ~sc1_mask()) == '0) |-> !top_word[SUM1_BIT]);                          // R6
    AST_SUM2_SHORTCUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((pend_pad[2] & ~sc2_mask()) == '0) |-> !top_word[SUM2_BIT]);                          // R6
    AST_TOP_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        top_word[DW-1:TOP_USED] == '0);                                                        // R5

endmodule

// File: tb/irqc_banked_test.sv
module irqc_banked_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [71:0] src_level = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [71:0] en_m = '0;
    logic [7:0]  fctl_m = '0;

    always #2.5 clk = ~clk;

    irqc_banked uut (
        .clk(clk), .rst(rst), .src_level(src_level), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] m_b1();
        return src_level[39:8] & en_m[39:8];
    endfunction
    function automatic logic [31:0] m_b2();
        return src_level[71:40] & en_m[71:40];
    endfunction
    function automatic logic [31:0] m_top();
        logic [31:0] t = '0;
        logic [31:0] a = m_b1();
        logic [31:0] b = m_b2();
        logic [31:0] a_ns = a;
        logic [31:0] b_ns = b;
        a_ns[7] = 0; a_ns[9] = 0; a_ns[10] = 0; a_ns[18] = 0; a_ns[19] = 0;
        b_ns[21] = 0; b_ns[22] = 0; b_ns[23] = 0; b_ns[24] = 0; b_ns[25] = 0; b_ns[30] = 0;
        t[7:0] = src_level[7:0] & en_m[7:0];
        t[8]  = |a_ns;
        t[9]  = |b_ns;
        t[10] = a[7];  t[11] = a[9];  t[12] = a[10]; t[13] = a[18]; t[14] = a[19];
        t[15] = b[21]; t[16] = b[22]; t[17] = b[23]; t[18] = b[24]; t[19] = b[25];
        t[20] = b[30];
        return t;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
        case (a)
            8'h18: en_m[7:0]   = en_m[7:0]   | d[7:0];
            8'h10: en_m[39:8]  = en_m[39:8]  | d;
            8'h14: en_m[71:40] = en_m[71:40] | d;
            8'h24: en_m[7:0]   = en_m[7:0]   & ~d[7:0];
            8'h1C: en_m[39:8]  = en_m[39:8]  & ~d;
            8'h20: en_m[71:40] = en_m[71:40] & ~d;
            8'h0C: fctl_m = d[7:0];
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        rd(8'h00, m_top(), {tag, " R5 R6 R7 top"});
        rd(8'h04, m_b1(), {tag, " R4 bank1"});
        rd(8'h08, m_b2(), {tag, " R4 bank2"});
        rd(8'h18, {24'h0, en_m[7:0]}, {tag, " R9 loc en"});
        rd(8'h10, en_m[39:8], {tag, " R9 b1 en"});
        rd(8'h14, en_m[71:40], {tag, " R9 b2 en"});
        chk({tag, " R8 irq"}, {31'h0, cpu_irq}, {31'h0, |(src_level & en_m)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        src_level = {72{1'b1}};

        // R1 reset state
        rd(8'h00, 32'h0, "R1 top");
        rd(8'h04, 32'h0, "R1 b1");
        rd(8'h18, 32'h0, "R1 loc en");
        rd(8'h0C, 32'h0, "R1 fctl");
        chk("R1 irq", {31'h0, cpu_irq}, 32'h0);

        // R7/R6 shortcut only: bank1 pos 7 -> top bit 10, summary low
        src_level = '0;
        src_level[8+7] = 1'b1;
        wr(8'h10, 32'h0000_0080);
        rd(8'h00, 32'h0000_0400, "R7 b1 pos7 shortcut, R6 summary low");
        chk("R8 irq shortcut", {31'h0, cpu_irq}, 32'h1);
        src_level[8+8] = 1'b1;
        wr(8'h10, 32'h0000_0100);
        rd(8'h00, 32'h0000_0500, "R6 b1 summary with pos8");
        // bank2 pos 30 -> bit 20 only
        src_level = '0;
        src_level[40+30] = 1'b1;
        wr(8'h14, 32'h4000_0000);
        rd(8'h00, 32'h0010_0000, "R7 b2 pos30 shortcut, R6 summary low");
        src_level[40+0] = 1'b1;
        wr(8'h14, 32'h0000_0001);
        rd(8'h00, 32'h0010_0200, "R6 b2 summary with pos0");
        // R3 clear with zero bits preserved
        wr(8'h20, 32'h4000_0000);
        rd(8'h14, 32'h0000_0001, "R3 b2 clear one bit");
        // R4 pending write ignored
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0000_0180, "R4 pend write no effect b1 en");
        rd(8'h14, 32'h0000_0001, "R4 pend write no effect b2 en");
        // R9 clear regs read zero
        rd(8'h1C, 32'h0, "R9 clr b1 reads 0");
        rd(8'h24, 32'h0, "R9 clr loc reads 0");
        // R10 fctl
        wr(8'h0C, 32'h1234_56A5);
        rd(8'h0C, 32'h0000_00A5, "R10 fctl readback");
        // R11 unmapped
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h12, 32'hFFFF_FFFF);
        rd(8'h28, 32'h0, "R11 unmapped read");
        rd(8'h02, 32'h0, "R11 misaligned read");
        rd(8'h10, 32'h0000_0180, "R11 write ignored b1 en");
        rd(8'h0C, 32'h0000_00A5, "R11 write ignored fctl");
        // R5 local group, upper bits
        src_level = {72{1'b1}};
        wr(8'h18, 32'hFFFF_FF5A);
        rd(8'h18, 32'h0000_005A, "R9 R2 loc en width");
        check_all("directed");
        wr(8'h18, 32'h0000_00A5);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h00, 32'h001F_FFFF, "R5 R6 R7 all high");

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 5);
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 3) == 0) d = d & $urandom & $urandom;
            @(negedge clk);
            src_level = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            case (op)
                0: wr(8'h18, d);
                1: wr(8'h10, d);
                2: wr(8'h14, d);
                3: wr(8'h24, d);
                4: wr(8'h1C, d);
                default: wr(8'h20, d);
            endcase
            check_all("random R2 R3");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule